// File: doc/BRIEF.md
# Panel Protection Power Sequencer

This block decides when a flat panel may receive power and switches its two enables in a safe order. It runs entirely on a free-running local oscillator clock, so it keeps working when the incoming pixel clock disappears. Four health conditions are combined: the pixel clock is toggling, the serializer PLL reports lock, the PLL has not dropped lock too often within the current frame, and an external sync detector reports stable timing. A software panel enable must also be set.

When every condition holds, the panel supply enable rises first and the backlight enable follows after a programmable number of oscillator cycles. When any condition fails, the backlight goes off at once, the supply follows after a second programmable delay, and a programmable minimum off time must pass before a new power-up can begin. A bypass input lets power-up proceed on the software enable alone, ignoring the health checks.

Top module: `panel_pwr_seq`

## Requirements
- R1: After reset both `vdd_en` and `bkl_en` are low.
- R2: With `panel_en`=1 and all checks healthy, `vdd_en` rises and `bkl_en` rises exactly max(`up_dly`,1) oscillator cycles later; `bkl_en` is never high while `vdd_en` is low.
- R3: When the power-on condition drops while both enables are high, `bkl_en` falls on the next clock edge and `vdd_en` falls exactly max(`dn_dly`,1) cycles after `bkl_en`.
- R4: After `vdd_en` falls, it stays low for max(`off_dly`,1)+1 cycles when the power-on condition is already true again.
- R5: If `pix_tgl` shows no edge for MISS_CYCLES (default 12) oscillator cycles, the pixel clock counts as missing and the panel is powered down.
- R6: `pll_lock` low makes the checks unhealthy and powers the panel down.
- R7: Each 1-to-0 transition of `pll_lock` counts as one unlock event; when the count since the last rising edge of `vsync` exceeds `unlock_limit`, the checks stay unhealthy until the next rising edge of `vsync` clears the count. A count equal to the limit is still healthy.
- R8: The unlock counter saturates at 2^CNT_W-1 (15 by default) and never wraps back to a small value.
- R9: `sync_ok` low makes the checks unhealthy and powers the panel down.
- R10: With `prot_bypass`=1 and `panel_en`=1 the panel powers up and stays up even when the clock, lock and sync checks fail.
- R11: With `panel_en`=0 the panel stays off, regardless of `prot_bypass`.
- R12: If the power-on condition drops during the supply-to-backlight delay, `vdd_en` drops without `bkl_en` ever rising.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| osc_clk | input | 1 | Local oscillator clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pix_tgl | input | 1 | Level that toggles on every pixel clock edge (asynchronous) |
| pll_lock | input | 1 | Serializer PLL lock, synchronous to osc_clk |
| vsync | input | 1 | Vertical sync, synchronous to osc_clk; rising edge starts a frame |
| sync_ok | input | 1 | Sync detector verdict, 1 = stable timing |
| panel_en | input | 1 | Software panel enable |
| prot_bypass | input | 1 | 1 = ignore the health checks |
| unlock_limit | input | CNT_W | Highest unlock count per frame still judged stable |
| up_dly | input | DLY_W | Cycles from supply on to backlight on |
| dn_dly | input | DLY_W | Cycles from backlight off to supply off |
| off_dly | input | DLY_W | Minimum supply off time in cycles |
| vdd_en | output | 1 | Panel supply enable |
| bkl_en | output | 1 | Backlight enable |

## Verification
The bench measures the supply-to-backlight and backlight-to-supply gaps to the exact cycle, so an off-by-one timer or a reversed order shows up as a wrong count. It aborts a power-up inside the delay window, where a design that ignored the abort would light the backlight on a dead supply. It drives the unlock count to exactly the limit, just over it, and well past the counter maximum: a wrong comparison would power down at the limit, and a wrapping counter would come back healthy after twenty events. It stops the pixel clock and runs with bypass set, where a bypass that also skipped the software enable would power the panel with software asking for off.

// File: rtl/pps_pkg.sv
package pps_pkg;

  typedef enum logic [2:0] {
    PS_OFF  = 3'd0,
    PS_UP   = 3'd1,
    PS_ON   = 3'd2,
    PS_DN   = 3'd3,
    PS_COOL = 3'd4
  } pps_state_t;

  // A timed state lasts max(dly,1) cycles: it ends when tmr+1 reaches dly.
  function automatic logic timer_done(input logic [15:0] tmr, input logic [15:0] dly);
    return ({1'b0, tmr} + 17'd1) >= {1'b0, dly};
  endfunction

  // Power-on condition: software enable, and either bypass or all checks healthy.
  function automatic logic power_go(input logic sw_en, input logic bypass,
                                    input logic clk_ok, input logic pll_ok,
                                    input logic sync_good);
    return sw_en && (bypass || (clk_ok && pll_ok && sync_good));
  endfunction

endpackage

// File: rtl/pps_clk_loss.sv
module pps_clk_loss #(
  parameter int MISS_CYCLES = 12
) (
  input  logic osc_clk,
  input  logic rst_n,
  input  logic pix_tgl,
  output logic pix_edge,
  output logic clk_ok
);
  localparam int MW = $clog2(MISS_CYCLES + 1);
  localparam logic [MW-1:0] MISS_MAX = MW'(MISS_CYCLES);

  logic s1, s2, s_prev;
  logic [MW-1:0] idle_cnt;

  always_ff @(posedge osc_clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 1'b0;
      s2 <= 1'b0;
      s_prev <= 1'b0;
    end else begin
      s1 <= pix_tgl;
      s2 <= s1;
      s_prev <= s2;
    end
  end

  assign pix_edge = s2 ^ s_prev;

  always_ff @(posedge osc_clk or negedge rst_n) begin
    if (!rst_n) idle_cnt <= MISS_MAX;
    else if (pix_edge) idle_cnt <= '0;
    else if (idle_cnt != MISS_MAX) idle_cnt <= idle_cnt + 1'b1;
  end

  assign clk_ok = (idle_cnt != MISS_MAX);
endmodule

// File: rtl/pps_pll_mon.sv
module pps_pll_mon #(
  parameter int CNT_W = 4
) (
  input  logic             osc_clk,
  input  logic             rst_n,
  input  logic             pll_lock,
  input  logic             vsync,
  input  logic [CNT_W-1:0] unlock_limit,
  output logic             unlock_evt,
  output logic             vs_rise,
  output logic [CNT_W-1:0] unlock_cnt,
  output logic             pll_ok
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic lock_prev, vs_prev;

  always_ff @(posedge osc_clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_prev <= 1'b0;
      vs_prev <= 1'b0;
    end else begin
      lock_prev <= pll_lock;
      vs_prev <= vsync;
    end
  end

  assign unlock_evt = lock_prev && !pll_lock;
  assign vs_rise    = vsync && !vs_prev;

  always_ff @(posedge osc_clk or negedge rst_n) begin
    if (!rst_n) unlock_cnt <= '0;
    else if (vs_rise) unlock_cnt <= '0;
    else if (unlock_evt && unlock_cnt != CNT_MAX) unlock_cnt <= unlock_cnt + 1'b1;
  end

  assign pll_ok = pll_lock && (unlock_cnt <= unlock_limit);
endmodule

// File: rtl/pps_seq_fsm.sv
module pps_seq_fsm
  import pps_pkg::*;
#(
  parameter int DLY_W = 8
) (
  input  logic             osc_clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic [DLY_W-1:0] up_dly,
  input  logic [DLY_W-1:0] dn_dly,
  input  logic [DLY_W-1:0] off_dly,
  output logic             vdd_en,
  output logic             bkl_en
);
  pps_state_t st, nxt;
  logic [DLY_W-1:0] tmr;

  always_comb begin
    nxt = st;
    unique case (st)
      PS_OFF:  if (go) nxt = PS_UP;
      PS_UP:   if (!go) nxt = PS_COOL;
               else if (timer_done(16'(tmr), 16'(up_dly))) nxt = PS_ON;
      PS_ON:   if (!go) nxt = PS_DN;
      PS_DN:   if (timer_done(16'(tmr), 16'(dn_dly))) nxt = PS_COOL;
      PS_COOL: if (timer_done(16'(tmr), 16'(off_dly))) nxt = PS_OFF;
      default: nxt = PS_OFF;
    endcase
  end

  always_ff @(posedge osc_clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= PS_OFF;
      tmr <= '0;
    end else begin
      st  <= nxt;
      tmr <= (nxt != st) ? '0 : tmr + 1'b1;
    end
  end

  assign vdd_en = (st == PS_UP) || (st == PS_ON) || (st == PS_DN);
  assign bkl_en = (st == PS_ON);
endmodule

// File: rtl/panel_pwr_seq.sv
module panel_pwr_seq
  import pps_pkg::*;
#(
  parameter int MISS_CYCLES = 12,
  parameter int CNT_W = 4,
  parameter int DLY_W = 8
) (
  input  logic             osc_clk,
  input  logic             rst_n,
  input  logic             pix_tgl,
  input  logic             pll_lock,
  input  logic             vsync,
  input  logic             sync_ok,
  input  logic             panel_en,
  input  logic             prot_bypass,
  input  logic [CNT_W-1:0] unlock_limit,
  input  logic [DLY_W-1:0] up_dly,
  input  logic [DLY_W-1:0] dn_dly,
  input  logic [DLY_W-1:0] off_dly,
  output logic             vdd_en,
  output logic             bkl_en
);
  logic pix_edge, clk_ok, unlock_evt, vs_rise, pll_ok, go;
  logic [CNT_W-1:0] unlock_cnt;

  pps_clk_loss #(.MISS_CYCLES(MISS_CYCLES)) u_clk_loss (
    .osc_clk(osc_clk), .rst_n(rst_n), .pix_tgl(pix_tgl),
    .pix_edge(pix_edge), .clk_ok(clk_ok)
  );

  pps_pll_mon #(.CNT_W(CNT_W)) u_pll_mon (
    .osc_clk(osc_clk), .rst_n(rst_n), .pll_lock(pll_lock), .vsync(vsync),
    .unlock_limit(unlock_limit), .unlock_evt(unlock_evt), .vs_rise(vs_rise),
    .unlock_cnt(unlock_cnt), .pll_ok(pll_ok)
  );

  assign go = power_go(panel_en, prot_bypass, clk_ok, pll_ok, sync_ok);

  pps_seq_fsm #(.DLY_W(DLY_W)) u_fsm (
    .osc_clk(osc_clk), .rst_n(rst_n), .go(go),
    .up_dly(up_dly), .dn_dly(dn_dly), .off_dly(off_dly),
    .vdd_en(vdd_en), .bkl_en(bkl_en)
  );
endmodule

// File: rtl/panel_pwr_seq_chk.sv
module panel_pwr_seq_chk #(
  parameter int CNT_W = 4
) (
  input logic             osc_clk,
  input logic             rst_n,
  input logic             go,
  input logic             vdd_en,
  input logic             bkl_en,
  input logic             unlock_evt,
  input logic             vs_rise,
  input logic [CNT_W-1:0] unlock_cnt
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  // R2
  bkl_needs_vdd_chk: assert property (@(posedge osc_clk) disable iff (!rst_n)
    bkl_en |-> vdd_en);

  // R2
  bkl_after_vdd_chk: assert property (@(posedge osc_clk) disable iff (!rst_n)
    $rose(bkl_en) |-> $past(vdd_en));

  // R3
  vdd_after_bkl_chk: assert property (@(posedge osc_clk) disable iff (!rst_n)
    $fell(vdd_en) |-> $past(!bkl_en));

  // R3
  bkl_drop_chk: assert property (@(posedge osc_clk) disable iff (!rst_n)
    (bkl_en && !go) |=> !bkl_en);

  // R11
  up_needs_go_chk: assert property (@(posedge osc_clk) disable iff (!rst_n)
    $rose(vdd_en) |-> $past(go));

  // R8
  cnt_saturate_chk: assert property (@(posedge osc_clk) disable iff (!rst_n)
    (unlock_cnt == CNT_MAX && unlock_evt && !vs_rise) |=> (unlock_cnt == CNT_MAX));

  // R7
  cnt_clear_chk: assert property (@(posedge osc_clk) disable iff (!rst_n)
    vs_rise |=> (unlock_cnt == '0));
endmodule

bind panel_pwr_seq panel_pwr_seq_chk #(.CNT_W(CNT_W)) u_chk (
  .osc_clk(osc_clk), .rst_n(rst_n), .go(go), .vdd_en(vdd_en), .bkl_en(bkl_en),
  .unlock_evt(unlock_evt), .vs_rise(vs_rise), .unlock_cnt(unlock_cnt)
);

// File: tb/panel_pwr_seq_tb_top.sv
module panel_pwr_seq_tb_top;
  localparam int CNT_W = 4;
  localparam int DLY_W = 8;
  localparam int UPD = 5, DND = 4, OFFD = 6;

  logic osc_clk = 1'b0;
  logic rst_n = 1'b0;
  logic pix_tgl = 1'b0;
  logic pll_lock = 1'b1;
  logic vsync = 1'b0;
  logic sync_ok = 1'b1;
  logic panel_en = 1'b0;
  logic prot_bypass = 1'b0;
  logic [CNT_W-1:0] unlock_limit = 4'd3;
  logic [DLY_W-1:0] up_dly = DLY_W'(UPD);
  logic [DLY_W-1:0] dn_dly = DLY_W'(DND);
  logic [DLY_W-1:0] off_dly = DLY_W'(OFFD);
  logic vdd_en, bkl_en;
  logic pix_run = 1'b1;
  logic done = 1'b0;
  int errors = 0, checks = 0;

  always #2 osc_clk = ~osc_clk;

  panel_pwr_seq #(.MISS_CYCLES(12), .CNT_W(CNT_W), .DLY_W(DLY_W)) dut_i (
    .osc_clk(osc_clk), .rst_n(rst_n), .pix_tgl(pix_tgl), .pll_lock(pll_lock),
    .vsync(vsync), .sync_ok(sync_ok), .panel_en(panel_en), .prot_bypass(prot_bypass),
    .unlock_limit(unlock_limit), .up_dly(up_dly), .dn_dly(dn_dly), .off_dly(off_dly),
    .vdd_en(vdd_en), .bkl_en(bkl_en)
  );

  initial forever begin
    repeat (3) @(negedge osc_clk);
    if (pix_run) pix_tgl = ~pix_tgl;
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge osc_clk);
  endtask

  task automatic unlock_pulses(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge osc_clk); pll_lock = 1'b0;
      @(negedge osc_clk); pll_lock = 1'b1;
    end
  endtask

  task automatic vs_pulse();
    @(negedge osc_clk); vsync = 1'b1;
    @(negedge osc_clk); vsync = 1'b0;
  endtask

  // {panel_en, prot_bypass, sync_ok, pll_lock, pix_run, exp_vdd, exp_bkl}
  localparam logic [6:0] VEC [0:11] = '{
    7'b1_0_1_1_1_1_1,  // R2 all healthy
    7'b0_0_1_1_1_0_0,  // R11 software off
    7'b1_0_1_1_1_1_1,  // R2
    7'b1_0_0_1_1_0_0,  // R9 sync unstable
    7'b1_0_1_1_1_1_1,  // R2
    7'b1_0_1_0_1_0_0,  // R6 lock low (one unlock event)
    7'b1_0_1_1_1_1_1,  // R2
    7'b1_0_1_1_0_0_0,  // R5 pixel clock stopped
    7'b1_0_1_1_1_1_1,  // R2
    7'b1_1_0_0_0_1_1,  // R10 bypass over failed checks
    7'b0_1_1_1_1_0_0,  // R11 bypass without software enable
    7'b1_0_1_1_1_1_1   // R7 two events, limit three: healthy
  };

  initial begin
    int n;
    idle(3);
    // R1
    check("R1 vdd_en after reset", int'(vdd_en), 0);
    check("R1 bkl_en after reset", int'(bkl_en), 0);
    rst_n = 1'b1;
    idle(30);
    check("R1 vdd_en stays off with panel_en=0", int'(vdd_en), 0);

    foreach (VEC[i]) begin
      @(negedge osc_clk);
      panel_en = VEC[i][6]; prot_bypass = VEC[i][5]; sync_ok = VEC[i][4];
      pll_lock = VEC[i][3]; pix_run = VEC[i][2];
      idle(80);
      check($sformatf("R2/R5/R6/R9/R10/R11 vector %0d vdd_en", i), int'(vdd_en), int'(VEC[i][1]));
      check($sformatf("R2/R5/R6/R9/R10/R11 vector %0d bkl_en", i), int'(bkl_en), int'(VEC[i][0]));
    end

    // R3: down gap
    @(negedge osc_clk); panel_en = 1'b0;
    @(negedge osc_clk);
    check("R3 bkl_en off one edge after condition drop", int'(bkl_en), 0);
    check("R3 vdd_en still on after bkl_en drop", int'(vdd_en), 1);
    panel_en = 1'b1;  // R4: condition true again during the down sequence
    n = 0;
    while (vdd_en) begin @(negedge osc_clk); n++; end
    check("R3 backlight-to-supply gap", n, DND);
    n = 0;
    while (!vdd_en) begin @(negedge osc_clk); n++; end
    check("R4 minimum off time", n, OFFD + 1);
    // R2: up gap
    n = 0;
    while (!bkl_en) begin @(negedge osc_clk); n++; end
    check("R2 supply-to-backlight gap", n, UPD);

    // R12: abort during up delay
    @(negedge osc_clk); panel_en = 1'b0;
    idle(40);
    panel_en = 1'b1;
    while (!vdd_en) @(negedge osc_clk);
    panel_en = 1'b0;
    n = 0;
    for (int k = 0; k < 40; k++) begin
      @(negedge osc_clk);
      if (bkl_en) n++;
    end
    check("R12 backlight never on after aborted power-up", n, 0);
    check("R12 supply off after aborted power-up", int'(vdd_en), 0);

    // R7: count at limit is healthy, over limit is not
    unlock_limit = 4'd2;
    panel_en = 1'b1;
    vs_pulse();
    idle(60);
    unlock_pulses(2);
    idle(80);
    check("R7 two unlocks with limit two keeps panel on", int'(bkl_en), 1);
    unlock_pulses(1);
    idle(80);
    check("R7 three unlocks with limit two keeps panel off", int'(vdd_en), 0);
    vs_pulse();
    idle(80);
    check("R7 vsync clears the unlock count", int'(bkl_en), 1);

    // R8: saturation, limit 14, twenty events
    unlock_limit = 4'd14;
    vs_pulse();
    unlock_pulses(20);
    idle(80);
    check("R8 saturated count stays over limit", int'(vdd_en), 0);
    vs_pulse();
    idle(80);
    check("R8 recovery after vsync", int'(bkl_en), 1);

    // R5: a slow but present clock (edge every 9 cycles) is not missing
    n = 0;
    pix_run = 1'b0;
    for (int k = 0; k < 10; k++) begin
      idle(9);
      pix_tgl = ~pix_tgl;
      if (!bkl_en) n++;
    end
    check("R5 edges within the missing window keep panel on", n, 0);
    pix_run = 1'b1;

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge osc_clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule